// File: doc/BRIEF.md
# Chroma Subsampling Output Formatter

This block sits at the end of a video pipeline. It takes a 4:4:4 pixel stream with one luma and two chroma components per beat and turns it into a luma output plus one shared chroma output. With the formatter switched off, every beat keeps its full chroma pair: U goes out on the chroma port and V on a second chroma port.

With the formatter switched on, chroma is reduced to 4:2:2 or 4:1:1:

- A phase counter, restarted by a line-start marker, tracks the position of each beat inside its decimation group.
- A programmable phase picks which beat of the group supplies the retained chroma pair.
- In 4:2:2 the shared port alternates the two components, in an order set by a control pin.
- In 4:1:1 the shared port spreads 2-bit slices of both components over the four beats of a group.

Chroma can be sent as two's complement or as offset binary. Luma can have its black level lifted by 16 codes, with saturation at the top of the range.

The luma and chroma paths each have their own short delay line, so a system can line the two up downstream. Luma has a 0–3 clock coarse delay plus one optional extra clock. Chroma has one optional extra clock.

Both stream edges use valid/ready. Back-pressure is total: the whole pipeline advances only on cycles where `out_ready` is high. `in_ready` mirrors `out_ready`, and while `out_ready` is low every output holds its value. The control pins are static. They are meant to change only after the pipeline has been drained of valid beats.

Top module: `yuv_subsample_fmt`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `out_valid` is 0 and `out_y`, `out_c` and `out_v` are all 0.
- R2: `in_ready` equals `out_ready` in every cycle. A beat is taken only in a cycle where `in_valid` and `in_ready` are both high. In a cycle with `out_ready` low no state changes and all outputs keep their values.
- R3: With `cfg_fmt_en` = 0, each beat carries its own coded U on `out_c` and its own coded V on `out_v`.
- R4: An accepted beat with `in_sol` = 1 has phase 0. Every other accepted beat has the previous accepted phase plus one, modulo the group size. The group size is 4 in 4:1:1 and 2 otherwise. The retained U/V pair is loaded on the accepted beat whose phase equals `cfg_phase`; in 4:2:2 and bypass only bit 0 of `cfg_phase` counts. Each beat uses the retained pair as it stands after that beat's own load.
- R5: In 4:2:2 (`cfg_fmt_en` = 1, `cfg_mode411` = 0), a phase-0 beat carries the first component and a phase-1 beat carries the second. With `cfg_v_first` = 0 the order is U then V; with `cfg_v_first` = 1 it is V then U. Both components come from the retained pair.
- R6: In 4:1:1 (`cfg_fmt_en` = 1, `cfg_mode411` = 1), a beat of phase p carries bits [7-2p:6-2p] of the retained coded U in `out_c[7:6]`. It carries the same bits of the retained coded V in `out_c[3:2]`. All other bits of `out_c` are 0, and `cfg_v_first` has no effect.
- R7: With `cfg_fmt_en` = 1, `out_v` is 0.
- R8: With `cfg_offbin` = 1, bit 7 of each chroma value is inverted before it is placed on an output. With `cfg_offbin` = 0, chroma is passed as two's complement.
- R9: With `cfg_keep_black` = 0, `out_y` is input Y plus 16, saturating at 255. With `cfg_keep_black` = 1, `out_y` is input Y unchanged.
- R10: A beat accepted at pipeline step k shows up as follows. Its chroma and `out_valid` appear after 1 + `cfg_cx` steps. Its luma appears after 1 + `cfg_ydly` + `cfg_yx` steps. Each step is a cycle with `out_ready` high.
- R11: A step in which no beat is accepted puts an empty beat into both paths: `out_valid` 0, with luma and chroma 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take a beat (mirrors out_ready) |
| in_sol | input | 1 | Marks the first beat of a line |
| in_y | input | 8 | Input luma |
| in_u | input | 8 | Input U, two's complement |
| in_v | input | 8 | Input V, two's complement |
| out_valid | output | 1 | Output beat present (aligned to chroma path) |
| out_ready | input | 1 | Downstream accepts; advances the pipeline |
| out_y | output | 8 | Output luma |
| out_c | output | 8 | Shared chroma output |
| out_v | output | 8 | V output in bypass mode, 0 otherwise |
| cfg_fmt_en | input | 1 | 0 = 4:4:4 bypass, 1 = subsampling on |
| cfg_mode411 | input | 1 | 0 = 4:2:2, 1 = 4:1:1 |
| cfg_phase | input | 2 | Group position that supplies retained chroma |
| cfg_offbin | input | 1 | 0 = two's complement, 1 = offset binary chroma |
| cfg_keep_black | input | 1 | 0 = lift luma black by 16, 1 = luma unchanged |
| cfg_v_first | input | 1 | 4:2:2 order: 0 = U first, 1 = V first |
| cfg_ydly | input | 2 | Coarse luma delay, 0–3 steps |
| cfg_yx | input | 1 | Extra luma delay step |
| cfg_cx | input | 1 | Extra chroma delay step |

## Verification
The assertions assume the control pins change only while the pipeline holds no valid beat. Under that assumption, mode-specific properties hold for every beat in flight:

- the zero bits of the 4:1:1 layout,
- a silent `out_v`,
- a lifted luma floor when both paths are equally delayed.

They also assume `rst_n` is released only once. Before each new control set, the stimulus drains the pipeline with eight empty steps while `out_ready` is high. It starts each run with a line-start beat, then mixes random valid gaps, random back-pressure, extra line starts and luma values near the top of the range.

// File: rtl/yuvf_pkg.sv
package yuvf_pkg;
  localparam int unsigned PIX_W   = 8;
  localparam int unsigned GRP_MAX = 4;

  typedef enum logic [1:0] {
    LAY_444 = 2'd0,
    LAY_422 = 2'd1,
    LAY_411 = 2'd2
  } layout_e;
endpackage

// File: rtl/yuvf_phase.sv
module yuvf_phase
  import yuvf_pkg::*;
#(
  parameter int unsigned W   = PIX_W,
  parameter int unsigned GRP = GRP_MAX,
  localparam int unsigned PW = $clog2(GRP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          sol,
  input  layout_e       lay,
  input  logic [PW-1:0] sel,
  input  logic [W-1:0]  u_in,
  input  logic [W-1:0]  v_in,
  output logic [PW-1:0] phase,
  output logic [W-1:0]  ku_eff,
  output logic [W-1:0]  kv_eff
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] mask;
  logic [W-1:0]  ku_q, kv_q;
  logic          hit;

  // group size follows layout: full group in 4:1:1, pairs otherwise
  assign mask   = (lay == LAY_411) ? PW'(GRP - 1) : PW'(1);
  assign phase  = (sol ? '0 : cnt_q) & mask;
  assign hit    = (phase == (sel & mask));
  assign ku_eff = hit ? u_in : ku_q;
  assign kv_eff = hit ? v_in : kv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ku_q  <= '0;
      kv_q  <= '0;
    end else if (accept) begin
      cnt_q <= (phase + PW'(1)) & mask;
      if (hit) begin
        ku_q <= u_in;
        kv_q <= v_in;
      end
    end
  end
endmodule

// File: rtl/yuvf_pack.sv
module yuvf_pack
  import yuvf_pkg::*;
#(
  parameter int unsigned W   = PIX_W,
  parameter int unsigned GRP = GRP_MAX,
  localparam int unsigned PW  = $clog2(GRP),
  localparam int unsigned SL  = W / GRP,
  localparam int unsigned BLK = 1 << (W - 4)
) (
  input  logic          accept,
  input  layout_e       lay,
  input  logic [PW-1:0] phase,
  input  logic          v_first,
  input  logic          offbin,
  input  logic          keep_black,
  input  logic [W-1:0]  y_in,
  input  logic [W-1:0]  u_in,
  input  logic [W-1:0]  v_in,
  input  logic [W-1:0]  ku_eff,
  input  logic [W-1:0]  kv_eff,
  output logic          o_vld,
  output logic [W-1:0]  o_y,
  output logic [W-1:0]  o_c,
  output logic [W-1:0]  o_v
);
  function automatic logic [W-1:0] code(input logic [W-1:0] x, input logic ob);
    code = ob ? {~x[W-1], x[W-2:0]} : x;
  endfunction

  logic [W:0]   y_sum;
  logic [W-1:0] y_lift;
  logic [W-1:0] cu, cv, first_c, second_c;
  logic [SL-1:0] u_sl, v_sl;

  assign y_sum  = {1'b0, y_in} + (W+1)'(BLK);
  assign y_lift = y_sum[W] ? '1 : y_sum[W-1:0];

  assign cu       = code(ku_eff, offbin);
  assign cv       = code(kv_eff, offbin);
  assign first_c  = v_first ? cv : cu;
  assign second_c = v_first ? cu : cv;

  always_comb begin
    u_sl = '0;
    v_sl = '0;
    for (int i = 0; i < int'(GRP); i++) begin
      if (phase == PW'(i)) begin
        u_sl = cu[W-1-SL*i -: SL];
        v_sl = cv[W-1-SL*i -: SL];
      end
    end
  end

  always_comb begin
    o_vld = 1'b0;
    o_y   = '0;
    o_c   = '0;
    o_v   = '0;
    if (accept) begin
      o_vld = 1'b1;
      o_y   = keep_black ? y_in : y_lift;
      unique case (lay)
        LAY_444: begin
          o_c = code(u_in, offbin);
          o_v = code(v_in, offbin);
        end
        LAY_422: o_c = phase[0] ? second_c : first_c;
        LAY_411: begin
          o_c[W-1 -: SL]   = u_sl;
          o_c[W/2-1 -: SL] = v_sl;
        end
        default: o_c = '0;
      endcase
    end
  end
endmodule

// File: rtl/yuvf_tap_delay.sv
module yuvf_tap_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned SW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [W-1:0]  d,
  input  logic [SW-1:0] sel,
  output logic [W-1:0]  q
);
  logic [W-1:0] stage_q [DEPTH];

  generate
    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  stage_q[g] <= '0;
        else if (en) stage_q[g] <= (g == 0) ? d : stage_q[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  always_comb begin
    q = d;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (sel == SW'(i + 1)) q = stage_q[i];
    end
  end
endmodule

// File: rtl/yuv_subsample_fmt.sv
module yuv_subsample_fmt
  import yuvf_pkg::*;
#(
  parameter int unsigned W        = PIX_W,
  parameter int unsigned GRP      = GRP_MAX,
  parameter int unsigned YDLY_MAX = 3,
  parameter int unsigned CDLY_MAX = 1,
  localparam int unsigned PW  = $clog2(GRP),
  localparam int unsigned YDW = $clog2(YDLY_MAX + 1),
  localparam int unsigned YD  = YDLY_MAX + 1,
  localparam int unsigned YSW = $clog2(YD + 1),
  localparam int unsigned CSW = $clog2(CDLY_MAX + 1),
  localparam int unsigned CW  = 1 + 2 * W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_sol,
  input  logic [W-1:0]   in_y,
  input  logic [W-1:0]   in_u,
  input  logic [W-1:0]   in_v,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_y,
  output logic [W-1:0]   out_c,
  output logic [W-1:0]   out_v,
  input  logic           cfg_fmt_en,
  input  logic           cfg_mode411,
  input  logic [PW-1:0]  cfg_phase,
  input  logic           cfg_offbin,
  input  logic           cfg_keep_black,
  input  logic           cfg_v_first,
  input  logic [YDW-1:0] cfg_ydly,
  input  logic           cfg_yx,
  input  logic           cfg_cx
);
  logic          step, accept;
  layout_e       lay;
  logic [PW-1:0] phase;
  logic [W-1:0]  ku_eff, kv_eff;
  logic          f_vld;
  logic [W-1:0]  f_y, f_c, f_v;
  logic          s1_vld;
  logic [W-1:0]  s1_y, s1_c, s1_v;
  logic [YSW-1:0] y_sel;
  logic [CSW-1:0] c_sel;
  logic [CW-1:0]  c_out;

  // whole pipeline moves only when downstream takes a beat
  assign step     = out_ready;
  assign in_ready = out_ready;
  assign accept   = in_valid && step;

  assign lay = !cfg_fmt_en ? LAY_444 : (cfg_mode411 ? LAY_411 : LAY_422);

  yuvf_phase #(.W(W), .GRP(GRP)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .sol    (in_sol),
    .lay    (lay),
    .sel    (cfg_phase),
    .u_in   (in_u),
    .v_in   (in_v),
    .phase  (phase),
    .ku_eff (ku_eff),
    .kv_eff (kv_eff)
  );

  yuvf_pack #(.W(W), .GRP(GRP)) u_pack (
    .accept     (accept),
    .lay        (lay),
    .phase      (phase),
    .v_first    (cfg_v_first),
    .offbin     (cfg_offbin),
    .keep_black (cfg_keep_black),
    .y_in       (in_y),
    .u_in       (in_u),
    .v_in       (in_v),
    .ku_eff     (ku_eff),
    .kv_eff     (kv_eff),
    .o_vld      (f_vld),
    .o_y        (f_y),
    .o_c        (f_c),
    .o_v        (f_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_y   <= '0;
      s1_c   <= '0;
      s1_v   <= '0;
    end else if (step) begin
      s1_vld <= f_vld;
      s1_y   <= f_y;
      s1_c   <= f_c;
      s1_v   <= f_v;
    end
  end

  assign y_sel = YSW'(cfg_ydly) + YSW'(cfg_yx);
  assign c_sel = CSW'(cfg_cx);

  yuvf_tap_delay #(.W(W), .DEPTH(YD)) u_ydly (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (step),
    .d     (s1_y),
    .sel   (y_sel),
    .q     (out_y)
  );

  yuvf_tap_delay #(.W(CW), .DEPTH(CDLY_MAX)) u_cdly (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (step),
    .d     ({s1_vld, s1_c, s1_v}),
    .sel   (c_sel),
    .q     (c_out)
  );

  assign out_valid = c_out[CW-1];
  assign out_c     = c_out[2*W-1:W];
  assign out_v     = c_out[W-1:0];
endmodule

// File: rtl/yuv_subsample_fmt_chk.sv
module yuv_subsample_fmt_chk #(
  parameter int unsigned W   = 8,
  parameter int unsigned GRP = 4,
  localparam int unsigned SL  = W / GRP,
  localparam int unsigned BLK = 1 << (W - 4),
  localparam logic [W-1:0] KEEP_MASK =
    W'(((1 << SL) - 1) << (W - SL)) | W'(((1 << SL) - 1) << (W/2 - SL))
) (
  input logic         clk,
  input logic         rst_n,
  input logic         out_ready,
  input logic         out_valid,
  input logic [W-1:0] out_y,
  input logic [W-1:0] out_c,
  input logic [W-1:0] out_v,
  input logic         cfg_fmt_en,
  input logic         cfg_mode411,
  input logic         cfg_keep_black,
  input logic [1:0]   cfg_ydly,
  input logic         cfg_yx,
  input logic         cfg_cx
);
  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> ($stable(out_y) && $stable(out_c) && $stable(out_v) && $stable(out_valid)));

  // R6
  slice_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fmt_en && cfg_mode411 && out_valid) |-> ((out_c & ~KEEP_MASK) == '0));

  // R7
  v_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fmt_en |-> (out_v == '0));

  // R9
  lift_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_keep_black && out_valid && (({1'b0, cfg_ydly} + {2'b00, cfg_yx}) == {2'b00, cfg_cx}))
      |-> (out_y >= W'(BLK)));
endmodule

bind yuv_subsample_fmt yuv_subsample_fmt_chk #(.W(W), .GRP(GRP)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .out_ready      (out_ready),
  .out_valid      (out_valid),
  .out_y          (out_y),
  .out_c          (out_c),
  .out_v          (out_v),
  .cfg_fmt_en     (cfg_fmt_en),
  .cfg_mode411    (cfg_mode411),
  .cfg_keep_black (cfg_keep_black),
  .cfg_ydly       (cfg_ydly),
  .cfg_yx         (cfg_yx),
  .cfg_cx         (cfg_cx)
);

// File: tb/yuv_subsample_fmt_test.sv
`timescale 1ns/1ps
module yuv_subsample_fmt_test;
  localparam int HN = 32768;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sol = 0, out_ready = 0;
  logic [7:0] in_y = 0, in_u = 0, in_v = 0;
  logic in_ready, out_valid;
  logic [7:0] out_y, out_c, out_v;
  logic cfg_fmt_en = 0, cfg_mode411 = 0, cfg_offbin = 0, cfg_keep_black = 1;
  logic cfg_v_first = 0, cfg_yx = 0, cfg_cx = 0;
  logic [1:0] cfg_phase = 0, cfg_ydly = 0;

  int checks = 0, fails = 0;
  bit done = 0, live = 0;

  always #2.5 clk = ~clk;

  yuv_subsample_fmt uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol),
    .in_y(in_y), .in_u(in_u), .in_v(in_v), .out_valid(out_valid), .out_ready(out_ready),
    .out_y(out_y), .out_c(out_c), .out_v(out_v), .cfg_fmt_en(cfg_fmt_en),
    .cfg_mode411(cfg_mode411), .cfg_phase(cfg_phase), .cfg_offbin(cfg_offbin),
    .cfg_keep_black(cfg_keep_black), .cfg_v_first(cfg_v_first), .cfg_ydly(cfg_ydly),
    .cfg_yx(cfg_yx), .cfg_cx(cfg_cx)
  );

  // behavioural reference: one history entry per pipeline step (R10, R11)
  int hy [HN]; int hc [HN]; int hv [HN]; bit hval [HN];
  int n = 0;
  int m_cnt = 0, m_ku = 0, m_kv = 0;

  function automatic int code(input int x);
    return cfg_offbin ? (x ^ 128) : x;   // R8 offset binary flips MSB
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && out_ready) begin
      int grp, ph, ey, ec, ev, a, b, sh;
      bit ok;
      ok = 0; ey = 0; ec = 0; ev = 0;
      if (in_valid) begin
        ok  = 1;
        grp = (cfg_fmt_en && cfg_mode411) ? 4 : 2;          // R4 group size
        ph  = in_sol ? 0 : (m_cnt % grp);
        if (ph == (cfg_phase % grp)) begin m_ku = in_u; m_kv = in_v; end
        m_cnt = (ph + 1) % grp;
        ey = cfg_keep_black ? in_y : ((in_y + 16 > 255) ? 255 : in_y + 16);   // R9
        if (!cfg_fmt_en) begin                                // R3
          ec = code(in_u); ev = code(in_v);
        end else if (!cfg_mode411) begin                      // R5
          a = cfg_v_first ? code(m_kv) : code(m_ku);
          b = cfg_v_first ? code(m_ku) : code(m_kv);
          ec = (ph == 0) ? a : b;
        end else begin                                        // R6
          sh = 6 - 2 * ph;
          ec = (((code(m_ku) >> sh) & 3) << 6) | (((code(m_kv) >> sh) & 3) << 2);
        end
      end
      hy[n] = ey; hc[n] = ec; hv[n] = ev; hval[n] = ok;
      n++;
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      int iy, ic;
      string ctag;
      iy = n - 1 - (cfg_ydly + cfg_yx);
      ic = n - 1 - cfg_cx;
      ctag = !cfg_fmt_en ? "R3 R8" : (cfg_mode411 ? "R4 R6 R8" : "R4 R5 R8");
      check("R2 in_ready", in_ready, out_ready);
      check("R10 R11 out_valid", out_valid, (ic >= 0) ? hval[ic] : 0);
      check("R9 R10 R11 out_y", out_y, (iy >= 0) ? hy[iy] : 0);
      check({ctag, " R10 out_c"}, out_c, (ic >= 0) ? hc[ic] : 0);
      check(cfg_fmt_en ? "R7 out_v" : "R3 out_v", out_v, (ic >= 0) ? hv[ic] : 0);
    end
  end

  task automatic run_cfg(input bit fe, input bit m4, input int ph, input bit ob, input bit kb,
                         input bit vf, input int yd, input bit yx, input bit cx, input int beats);
    in_valid = 0; in_sol = 0; out_ready = 1;
    repeat (8) @(negedge clk);
    cfg_fmt_en = fe; cfg_mode411 = m4; cfg_phase = 2'(ph); cfg_offbin = ob;
    cfg_keep_black = kb; cfg_v_first = vf; cfg_ydly = 2'(yd); cfg_yx = yx; cfg_cx = cx;
    for (int i = 0; i < beats; i++) begin
      @(negedge clk);
      out_ready = (i < 2) || (($urandom % 7) != 0);
      in_valid  = (i < 2) || (($urandom % 5) != 0);
      in_sol    = (i < 2) || (($urandom % 37) == 0);
      in_y = (($urandom % 4) == 0) ? 8'(236 + $urandom % 20) : 8'($urandom);
      in_u = 8'($urandom);
      in_v = 8'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", out_valid, 0);
    check("R1 out_y", out_y, 0);
    check("R1 out_c", out_c, 0);
    check("R1 out_v", out_v, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 out_valid after release", out_valid, 0);
    live = 1;
    run_cfg(0, 0, 0, 0, 1, 0, 0, 0, 0, 300);  // bypass R3
    run_cfg(0, 0, 0, 1, 0, 0, 2, 1, 0, 300);  // bypass, offbin R8, lift R9
    run_cfg(1, 0, 0, 0, 1, 0, 0, 0, 0, 300);  // 4:2:2 U first R5
    run_cfg(1, 0, 1, 1, 0, 1, 1, 0, 1, 300);  // 4:2:2 V first, phase 1 R4
    run_cfg(1, 0, 3, 0, 0, 0, 3, 1, 1, 300);  // only low phase bit counts R4
    for (int p = 0; p < 4; p++)               // 4:1:1 each phase R4 R6
      run_cfg(1, 1, p, p[0], p[1], p[0], p, p[1], p[0], 300);
    run_cfg(1, 1, 2, 1, 0, 1, 0, 0, 1, 300);  // v_first ignored in 4:1:1 R6
    run_cfg(1, 0, 0, 0, 0, 0, 3, 1, 0, 300);  // maximum luma delay R10
    in_valid = 0; out_ready = 1;
    repeat (8) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule